// File: doc/BRIEF.md
# Pixel Clock Frequency Meter

This block gives a rough measure of a pixel clock's rate against a free-running reference clock. Software writes an 8-bit interval `N` through the reference-domain register port. The write sets the window length and starts the measurement at once. During a window of `N` reference periods the block counts rising edges of the pixel clock. When the window closes, the count is held for readback through the same port.

Pixel edges are counted by a free-running Gray-coded counter in the pixel domain. Its value crosses into the reference domain through a multi-flop synchronizer and is converted back to binary there. The reference-domain controller takes one snapshot of that value when the write is accepted and another when the window expires. The result is the difference between the two snapshots, clamped at 0xFF. `busy` is high from the write until the result is latched. `done` then pulses for one cycle.

The controller is a three-state machine. The states are WIN_IDLE, WIN_MEASURE and WIN_SETTLE, and they move on these transitions:
- T_START: WIN_IDLE to WIN_MEASURE on a non-zero write.
- T_EXPIRE: WIN_MEASURE to WIN_SETTLE when the timer reaches its last cycle.
- T_LATCH: WIN_SETTLE to WIN_IDLE, which writes the result.
- T_RESTART: WIN_MEASURE or WIN_SETTLE back to WIN_MEASURE on a non-zero write.
- T_ABORT: any state to WIN_IDLE on a zero write.

Top module: `fm_freq_meter`

## Requirements
- R1: After reset, `rd_data` is 0, and `busy` and `done` are low.
- R2: A write of non-zero `N` raises `busy` at the next reference edge. `busy` then stays high for exactly `N+1` reference cycles: `N` cycles of window and one latch cycle.
- R3: The latched result equals the number of pixel rising edges in a window of `N` reference periods, within ±1. This holds when that number is below 255 and below 2^CNT_W.
- R4: When the edge count in the window reaches 255 or more, the result is 0xFF (all ones) and never wraps. This holds for counts below 2^CNT_W.
- R5: A write of 0 starts no window. It sets `rd_data` to 0 and drives `busy` low at the next reference edge, abandoning any window in progress.
- R6: A non-zero write while `busy` is high restarts the measurement with the new interval. `busy` then lasts `N+1` cycles from the new write, and the result reflects only the new window.
- R7: While `busy` is high, `rd_data` keeps the previous result unchanged.
- R8: `done` is high for exactly one cycle. That cycle is the first one with `busy` low after a completed window, and `rd_data` already holds the new result in it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Reference oscillator clock |
| ref_rst_n | input | 1 | Active-low asynchronous reset, reference domain |
| pix_clk | input | 1 | Pixel clock being measured |
| pix_rst_n | input | 1 | Active-low asynchronous reset, pixel domain |
| wr_en | input | 1 | Register write strobe (reference domain) |
| wr_data | input | REG_W | Interval in reference periods; 0 aborts |
| rd_data | output | REG_W | Last latched saturated edge count |
| busy | output | 1 | Measurement in progress |
| done | output | 1 | One-cycle pulse when a result is latched |

## Verification
The bench builds the block with `CNT_W=10` and `SYNC_STAGES=3`. With a 10-bit pixel counter, the free-running count wraps every 1024 pixel edges. Long random sequences therefore take snapshots on both sides of a wrap, which exercises the modular difference as well as the clamp at 0xFF. The pixel clock is swept over periods from 7.3 ns to 45 ns against the 20 ns reference. This covers counts from a few edges up to about 700, above the clamp but still below 1024. The deeper synchronizer stretches the snapshot latency without changing the expected counts.

// File: rtl/fm_pkg.sv
package fm_pkg;

    typedef enum logic [1:0] {
        WIN_IDLE    = 2'd0,
        WIN_MEASURE = 2'd1,
        WIN_SETTLE  = 2'd2
    } win_state_e;

endpackage

// File: rtl/fm_gray_cnt.sv
module fm_gray_cnt #(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [CNT_W-1:0] gray
);

    logic [CNT_W-1:0] bin_q;
    logic [CNT_W-1:0] bin_nx;
    logic [CNT_W-1:0] gray_q;

    assign bin_nx = bin_q + 1'b1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bin_q  <= '0;
            gray_q <= '0;
        end else begin
            bin_q  <= bin_nx;
            gray_q <= bin_nx ^ (bin_nx >> 1);
        end
    end

    assign gray = gray_q;

    AST_GRAY_ONE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(gray_q ^ $past(gray_q)) <= 1); // R3

endmodule

// File: rtl/fm_gray_rx.sv
module fm_gray_rx #(
    parameter int W      = 12,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] gray_in,
    output logic [W-1:0] bin_out
);

    localparam int LAST = STAGES - 1;

    logic [STAGES-1:0][W-1:0] stg_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stg_q <= '0;
        end else begin
            stg_q <= {stg_q[STAGES-2:0], gray_in};
        end
    end

    genvar b;
    generate
        for (b = 0; b < W; b++) begin : g_g2b
            assign bin_out[b] = ^stg_q[LAST][W-1:b];
        end
    endgenerate

endmodule

// File: rtl/fm_window_ctl.sv
module fm_window_ctl
    import fm_pkg::*;
#(
    parameter int REG_W = 8,
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    input  logic [CNT_W-1:0] cnt_bin,
    output logic [REG_W-1:0] rd_data,
    output logic             busy,
    output logic             done
);

    localparam logic [CNT_W-1:0] SAT_LIM = CNT_W'((2 ** REG_W) - 1);

    win_state_e       state_q, state_nx;
    logic [REG_W-1:0] tmr_q;
    logic [CNT_W-1:0] start_q;
    logic [CNT_W-1:0] end_q;
    logic [REG_W-1:0] res_q;
    logic             done_q;
    logic [CNT_W-1:0] diff;
    logic [REG_W-1:0] sat_val;
    logic             wr_start;
    logic             wr_zero;

    assign wr_start = wr_en && (wr_data != '0);
    assign wr_zero  = wr_en && (wr_data == '0);
    assign diff     = end_q - start_q;
    assign sat_val  = (diff > SAT_LIM) ? '1 : diff[REG_W-1:0];

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= WIN_IDLE;
        else        state_q <= state_nx;
    end

    // next state
    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            WIN_IDLE: begin
                if (wr_start) state_nx = WIN_MEASURE;          // T_START
            end
            WIN_MEASURE: begin
                if (wr_start)          state_nx = WIN_MEASURE; // T_RESTART
                else if (wr_zero)      state_nx = WIN_IDLE;    // T_ABORT
                else if (tmr_q == 1)   state_nx = WIN_SETTLE;  // T_EXPIRE
            end
            WIN_SETTLE: begin
                if (wr_start)          state_nx = WIN_MEASURE; // T_RESTART
                else                   state_nx = WIN_IDLE;    // T_LATCH / T_ABORT
            end
            default: state_nx = WIN_IDLE;
        endcase
    end

    // datapath and registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tmr_q   <= '0;
            start_q <= '0;
            end_q   <= '0;
            res_q   <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (wr_zero) begin
                res_q <= '0;
                tmr_q <= '0;
            end else if (wr_start) begin
                start_q <= cnt_bin;
                tmr_q   <= wr_data;
            end else begin
                unique case (state_q)
                    WIN_MEASURE: begin
                        tmr_q <= tmr_q - 1'b1;
                        if (tmr_q == 1) end_q <= cnt_bin;
                    end
                    WIN_SETTLE: begin
                        res_q  <= sat_val;
                        done_q <= 1'b1;
                    end
                    default: ;
                endcase
            end
        end
    end

    assign busy    = (state_q != WIN_IDLE);
    assign rd_data = res_q;
    assign done    = done_q;

    AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        wr_start |=> busy); // R2
    AST_TMR_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == WIN_MEASURE) |-> (tmr_q != '0)); // R2
    AST_ZERO_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
        wr_zero |=> (rd_data == '0 && !busy)); // R5
    AST_HOLD_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(busy) && busy) |-> $stable(rd_data)); // R7
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R8
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy); // R8

endmodule

// File: rtl/fm_freq_meter.sv
module fm_freq_meter #(
    parameter int REG_W       = 8,
    parameter int CNT_W       = 12,
    parameter int SYNC_STAGES = 2
) (
    input  logic             ref_clk,
    input  logic             ref_rst_n,
    input  logic             pix_clk,
    input  logic             pix_rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] rd_data,
    output logic             busy,
    output logic             done
);

    logic [CNT_W-1:0] pix_gray;
    logic [CNT_W-1:0] ref_bin;

    fm_gray_cnt #(.CNT_W(CNT_W)) u_cnt (
        .clk   (pix_clk),
        .rst_n (pix_rst_n),
        .gray  (pix_gray)
    );

    fm_gray_rx #(.W(CNT_W), .STAGES(SYNC_STAGES)) u_rx (
        .clk     (ref_clk),
        .rst_n   (ref_rst_n),
        .gray_in (pix_gray),
        .bin_out (ref_bin)
    );

    fm_window_ctl #(.REG_W(REG_W), .CNT_W(CNT_W)) u_ctl (
        .clk     (ref_clk),
        .rst_n   (ref_rst_n),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .cnt_bin (ref_bin),
        .rd_data (rd_data),
        .busy    (busy),
        .done    (done)
    );

endmodule

// File: tb/sim_fm_freq_meter.sv
`timescale 1ns/1ps
module sim_fm_freq_meter;

    localparam real REF_T = 20.0;

    logic       ref_clk = 1'b0;
    logic       pix_clk = 1'b0;
    logic       ref_rst_n = 1'b0;
    logic       pix_rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    logic       busy;
    logic       done;

    realtime pix_half = 10.0;
    int n_cmp = 0;
    int n_bad = 0;
    int cyc = 0;
    real periods [4] = '{45.0, 20.5, 13.0, 7.3};

    fm_freq_meter #(.REG_W(8), .CNT_W(10), .SYNC_STAGES(3)) u0 (
        .ref_clk(ref_clk), .ref_rst_n(ref_rst_n), .pix_clk(pix_clk),
        .pix_rst_n(pix_rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .busy(busy), .done(done)
    );

    always #10 ref_clk = ~ref_clk;
    always begin
        #(pix_half);
        pix_clk = ~pix_clk;
    end

    always @(posedge ref_clk) begin
        cyc <= cyc + 1;
        if (cyc == 150000) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: run did not finish, actual %0d cycles expected < 150000", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic real expect_count(input int n, input real tp);
        real e;
        e = (n * REF_T) / tp;
        return (e > 255.0) ? 255.0 : e;
    endfunction

    // write at a negedge, then count busy cycles until it drops
    task automatic measure(input int n, output int busy_cnt);
        @(negedge ref_clk);
        wr_en = 1'b1; wr_data = 8'(n);
        @(negedge ref_clk);
        wr_en = 1'b0;
        busy_cnt = 0;
        while (busy && busy_cnt < 400) begin
            busy_cnt++;
            @(negedge ref_clk);
        end
    endtask

    task automatic run_case(input int n, input int pidx, input string tag);
        int  bc;
        real e;
        int  er;
        pix_half = periods[pidx] / 2.0;
        repeat (4) @(negedge ref_clk);
        measure(n, bc);
        check(bc == n + 1, "R2 busy length", bc, n + 1);
        check(done == 1'b1, "R8 done at result", int'(done), 1);
        e  = expect_count(n, periods[pidx]);
        er = int'(e);
        check((real'(rd_data) - e) <= 1.0 && (e - real'(rd_data)) <= 1.0,
              tag, int'(rd_data), er);
        @(negedge ref_clk);
        check(done == 1'b0, "R8 done single cycle", int'(done), 0);
    endtask

    initial begin
        int bc;
        int prev;
        int unused;
        unused = $urandom(1234);
        repeat (3) @(negedge ref_clk);
        // R1: reset values
        check(rd_data == 8'd0, "R1 rd_data reset", int'(rd_data), 0);
        check(busy == 1'b0, "R1 busy reset", int'(busy), 0);
        check(done == 1'b0, "R1 done reset", int'(done), 0);
        pix_rst_n = 1'b1;
        ref_rst_n = 1'b1;
        repeat (5) @(negedge ref_clk);

        // directed: R3 counts at each ratio, R4 saturation
        run_case(50, 0, "R3 slow pixel");
        run_case(100, 1, "R3 near-equal pixel");
        run_case(1, 3, "R3 one-cycle window");
        run_case(60, 3, "R3 fast pixel");
        run_case(200, 3, "R4 saturation fast");
        run_case(255, 2, "R4 saturation max interval");

        // R7: reads during window keep previous result
        prev = int'(rd_data);
        pix_half = periods[0] / 2.0;
        @(negedge ref_clk);
        wr_en = 1'b1; wr_data = 8'd100;
        @(negedge ref_clk);
        wr_en = 1'b0;
        repeat (40) @(negedge ref_clk);
        check(busy == 1'b1, "R7 busy mid-window", int'(busy), 1);
        check(int'(rd_data) == prev, "R7 hold during window", int'(rd_data), prev);

        // R6: restart mid-window with a new interval
        measure(30, bc);
        check(bc == 31, "R6 restart busy length", bc, 31);
        check((real'(rd_data) - expect_count(30, 45.0)) <= 1.0 &&
              (expect_count(30, 45.0) - real'(rd_data)) <= 1.0,
              "R6 restart count", int'(rd_data), int'(expect_count(30, 45.0)));

        // R5: zero write aborts and clears
        @(negedge ref_clk);
        wr_en = 1'b1; wr_data = 8'd80;
        @(negedge ref_clk);
        wr_en = 1'b1; wr_data = 8'd0;
        @(negedge ref_clk);
        wr_en = 1'b0;
        check(busy == 1'b0, "R5 abort busy", int'(busy), 0);
        check(rd_data == 8'd0, "R5 abort clears", int'(rd_data), 0);
        repeat (100) @(negedge ref_clk);
        check(rd_data == 8'd0 && done == 1'b0, "R5 no late result", int'(rd_data), 0);

        // random windows and ratios
        for (int i = 0; i < 24; i++) begin
            run_case($urandom_range(1, 255), $urandom_range(0, 3), "R3 R4 random");
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule